// File: doc/BRIEF.md
# Coherence Snoop Responder

This block sits beside a small cache directory and answers bus transactions issued by other masters. It compares each snooped address with the directory at 32-byte block granularity and works out the response. From the transaction kind, the coherence-required (global) attribute and the current MESI state of the matching block, it chooses the shared and retry status it reports and the new state it writes into the directory. When modified data has to reach memory first, it raises a write-back request that is held until the write-back path acknowledges it.

Beside the directory the block holds two more pieces of snoop-visible state. The first is a single load-reserved reservation, which a global write-with-flush to the reserved block cancels. The second is a small posted write queue, whose entries a global write-with-kill to the same block purges. The local side fills directory lines, sets the reservation and loads queue slots through simple write ports. A probe port reads back the state of any block without side effects.

Top module: `snoop_ctl`

## Requirements
- R1: After reset, every directory line is Invalid and the shared and retry status, the write-back request, the reservation and all write-queue valid bits are low. MESI codes on fill_state and probe_state are I=0, S=1, E=2, M=3.
- R2: Status appears only in the single cycle after a sampled snoop, as a one-cycle pulse. A cycle without snp_valid, or a snoop with snp_global low, gives no status, no directory change, no reservation change and no queue change.
- R3: Global read (snp_type 0) and read-atomic (1): a block that is Invalid or absent gives nothing. S reports shared and is unchanged. E reports shared and becomes S. M reports shared and retry, raises a write-back and becomes S in the same cycle.
- R4: Global clean (2) acts only on M. It reports shared and retry, raises a write-back and becomes E in the same cycle. All other states give nothing.
- R5: Global flush (3), write-with-flush (4) and write-with-flush-atomic (5): S or E becomes I with no status. M reports shared and retry and raises a write-back, and stays M until the acknowledge, after which it becomes I.
- R6: Global kill (6) and write-with-kill (7) turn any valid matching block to I, with no status and no write-back.
- R7: While push_req is high and push_ack is low, push_req stays high and push_addr (the block address with offset bits zero) is unchanged. push_req drops in the cycle after an acknowledge.
- R8: While a write-back is outstanding, any global snoop reports retry only (shared low) and changes nothing.
- R9: A global write-with-flush or write-with-flush-atomic whose block equals the reserved block clears resv_valid, whether or not the cache holds the block. Other kinds, other blocks and non-global snoops leave it set.
- R10: A global write-with-kill clears every valid write-queue slot holding the same block. Kill (6) and non-global write-with-kill leave the queue unchanged.
- R11: Matching uses address bits [31:5] only. An address that differs only in bits [4:0] hits the same block, and a different tag with the same index misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snooped address tenure sampled this cycle |
| snp_addr | input | 32 | Snooped address |
| snp_type | input | 3 | Transaction kind code |
| snp_global | input | 1 | Coherence-required attribute |
| sts_shared | output | 1 | Shared snoop status |
| sts_retry | output | 1 | Retry snoop status |
| push_req | output | 1 | Write-back request |
| push_addr | output | 32 | Block address to write back |
| push_ack | input | 1 | Write-back acknowledge |
| fill_en | input | 1 | Install or overwrite a directory line |
| fill_addr | input | 32 | Address of the line to install |
| fill_state | input | 2 | MESI state to install |
| probe_addr | input | 32 | Address to look up |
| probe_state | output | 2 | MESI state of the probed block (I on miss) |
| resv_set | input | 1 | Set the reservation |
| resv_addr | input | 32 | Address to reserve |
| resv_valid | output | 1 | Reservation held |
| wq_wr | input | 1 | Write one write-queue slot |
| wq_slot | input | 2 | Slot index |
| wq_addr | input | 32 | Address stored in the slot |
| wq_wr_valid | input | 1 | Valid bit stored in the slot |
| wq_valid | output | 3 | Write-queue slot valid bits |

## Verification
The assertions assume the local ports never touch a block that a snoop updates in the same cycle, and that push_ack arrives only while push_req is high. The bench keeps to this by running each local write, snoop and acknowledge in a cycle of its own. It asserts push_ack only after it has seen the request. It installs a fresh line before each snoop, so the only directory activity in a snoop cycle is the snoop's own lookup.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    typedef enum logic [1:0] {
        MESI_I = 2'd0,
        MESI_S = 2'd1,
        MESI_E = 2'd2,
        MESI_M = 2'd3
    } mesi_t;

    typedef enum logic [2:0] {
        SNP_READ      = 3'd0,
        SNP_READ_ATOM = 3'd1,
        SNP_CLEAN     = 3'd2,
        SNP_FLUSH     = 3'd3,
        SNP_WFLUSH    = 3'd4,
        SNP_WFLUSH_AT = 3'd5,
        SNP_KILL      = 3'd6,
        SNP_WKILL     = 3'd7
    } snp_kind_t;

    typedef struct packed {
        logic  sh;
        logic  rt;
        logic  push;
        logic  wr_now;
        logic  wr_later;
        logic  drop_resv;
        logic  purge_wq;
        mesi_t nst;
    } snp_act_t;

endpackage

// File: rtl/snoop_policy.sv
module snoop_policy
    import snoop_pkg::*;
(
    input  snp_kind_t kind,
    input  mesi_t     cur,
    output snp_act_t  act
);
    always_comb begin
        act     = '0;
        act.nst = cur;
        case (kind)
            SNP_READ, SNP_READ_ATOM: begin
                case (cur)
                    MESI_S: act.sh = 1'b1;
                    MESI_E: begin
                        act.sh = 1'b1; act.wr_now = 1'b1; act.nst = MESI_S;
                    end
                    MESI_M: begin
                        act.sh = 1'b1; act.rt = 1'b1; act.push = 1'b1;
                        act.wr_now = 1'b1; act.nst = MESI_S;
                    end
                    default: ;
                endcase
            end
            SNP_CLEAN: begin
                if (cur == MESI_M) begin
                    act.sh = 1'b1; act.rt = 1'b1; act.push = 1'b1;
                    act.wr_now = 1'b1; act.nst = MESI_E;
                end
            end
            SNP_FLUSH, SNP_WFLUSH, SNP_WFLUSH_AT: begin
                act.drop_resv = (kind != SNP_FLUSH);
                case (cur)
                    MESI_S, MESI_E: begin
                        act.wr_now = 1'b1; act.nst = MESI_I;
                    end
                    MESI_M: begin
                        act.sh = 1'b1; act.rt = 1'b1; act.push = 1'b1;
                        act.wr_later = 1'b1; act.nst = MESI_I;
                    end
                    default: ;
                endcase
            end
            default: begin
                act.purge_wq = (kind == SNP_WKILL);
                if (cur != MESI_I) begin
                    act.wr_now = 1'b1; act.nst = MESI_I;
                end
            end
        endcase
    end
endmodule

// File: rtl/wq_match.sv
module wq_match #(
    parameter int DEPTH = 3,
    parameter int BLK_W = 27
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0][BLK_W-1:0] addr,
    input  logic [BLK_W-1:0]            blk,
    output logic [DEPTH-1:0]            hit
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = valid[i] && (addr[i] == blk);
    end
endmodule

// File: rtl/snoop_ctl.sv
module snoop_ctl
    import snoop_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_OFF   = 5,
    parameter int NUM_LINES = 4,
    parameter int WQ_DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [2:0]        snp_type,
    input  logic              snp_global,
    output logic              sts_shared,
    output logic              sts_retry,
    output logic              push_req,
    output logic [ADDR_W-1:0] push_addr,
    input  logic              push_ack,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [1:0]        fill_state,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [1:0]        probe_state,
    input  logic              resv_set,
    input  logic [ADDR_W-1:0] resv_addr,
    output logic              resv_valid,
    input  logic              wq_wr,
    input  logic [$clog2(WQ_DEPTH)-1:0] wq_slot,
    input  logic [ADDR_W-1:0] wq_addr,
    input  logic              wq_wr_valid,
    output logic [WQ_DEPTH-1:0] wq_valid
);
    localparam int BLK_W  = ADDR_W - BLK_OFF;
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = BLK_W - IDX_W;
    localparam int SLOT_W = $clog2(WQ_DEPTH);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WQ_DEPTH - 1);

    typedef struct packed {
        logic [NUM_LINES-1:0][TAG_W-1:0] tag;
        mesi_t [NUM_LINES-1:0]           st;
        logic                            sh;
        logic                            rt;
        logic                            push;
        logic [BLK_W-1:0]                paddr;
        logic                            pend;
        logic [IDX_W-1:0]                pidx;
        mesi_t                           pst;
        logic                            rv;
        logic [BLK_W-1:0]                raddr;
        logic [WQ_DEPTH-1:0]             wqv;
        logic [WQ_DEPTH-1:0][BLK_W-1:0]  wqa;
    } ctl_t;

    ctl_t q, d;

    logic [BLK_W-1:0]    s_blk, f_blk, p_blk;
    logic [IDX_W-1:0]    s_idx, f_idx, p_idx;
    logic [TAG_W-1:0]    s_tag, f_tag, p_tag;
    mesi_t               s_cur;
    snp_act_t            act;
    logic [WQ_DEPTH-1:0] wq_hit;

    assign s_blk = snp_addr[ADDR_W-1:BLK_OFF];
    assign s_idx = s_blk[IDX_W-1:0];
    assign s_tag = s_blk[BLK_W-1:IDX_W];
    assign f_blk = fill_addr[ADDR_W-1:BLK_OFF];
    assign f_idx = f_blk[IDX_W-1:0];
    assign f_tag = f_blk[BLK_W-1:IDX_W];
    assign p_blk = probe_addr[ADDR_W-1:BLK_OFF];
    assign p_idx = p_blk[IDX_W-1:0];
    assign p_tag = p_blk[BLK_W-1:IDX_W];

    assign s_cur = (q.tag[s_idx] == s_tag) ? q.st[s_idx] : MESI_I;

    snoop_policy u_policy (
        .kind (snp_kind_t'(snp_type)),
        .cur  (s_cur),
        .act  (act)
    );

    wq_match #(.DEPTH(WQ_DEPTH), .BLK_W(BLK_W)) u_wq_match (
        .valid (q.wqv),
        .addr  (q.wqa),
        .blk   (s_blk),
        .hit   (wq_hit)
    );

    always_comb begin
        d    = q;
        d.sh = 1'b0;
        d.rt = 1'b0;

        if (fill_en) begin
            d.tag[f_idx] = f_tag;
            d.st[f_idx]  = mesi_t'(fill_state);
        end
        if (wq_wr && (wq_slot <= LAST_SLOT)) begin
            d.wqv[wq_slot] = wq_wr_valid;
            d.wqa[wq_slot] = wq_addr[ADDR_W-1:BLK_OFF];
        end

        if (q.push && push_ack) begin
            d.push = 1'b0;
            if (q.pend) begin
                d.st[q.pidx] = q.pst;
                d.pend       = 1'b0;
            end
        end

        if (snp_valid && snp_global) begin
            if (q.push) begin
                d.rt = 1'b1;
            end else begin
                d.sh = act.sh;
                d.rt = act.rt;
                if (act.wr_now)
                    d.st[s_idx] = act.nst;
                if (act.push) begin
                    d.push  = 1'b1;
                    d.paddr = s_blk;
                end
                if (act.wr_later) begin
                    d.pend = 1'b1;
                    d.pidx = s_idx;
                    d.pst  = act.nst;
                end
                if (act.drop_resv && q.rv && (q.raddr == s_blk))
                    d.rv = 1'b0;
                if (act.purge_wq)
                    d.wqv = d.wqv & ~wq_hit;
            end
        end

        if (resv_set) begin
            d.rv    = 1'b1;
            d.raddr = resv_addr[ADDR_W-1:BLK_OFF];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sts_shared  = q.sh;
    assign sts_retry   = q.rt;
    assign push_req    = q.push;
    assign push_addr   = {q.paddr, {BLK_OFF{1'b0}}};
    assign probe_state = (q.tag[p_idx] == p_tag) ? q.st[p_idx] : MESI_I;
    assign resv_valid  = q.rv;
    assign wq_valid    = q.wqv;

endmodule

// File: rtl/snoop_ctl_chk.sv
module snoop_ctl_chk #(
    parameter int ADDR_W   = 32,
    parameter int WQ_DEPTH = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                snp_valid,
    input logic [2:0]          snp_type,
    input logic                snp_global,
    input logic                sts_shared,
    input logic                sts_retry,
    input logic                push_req,
    input logic [ADDR_W-1:0]   push_addr,
    input logic                push_ack,
    input logic                resv_valid,
    input logic                wq_wr,
    input logic [WQ_DEPTH-1:0] wq_valid
);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !sts_shared && !sts_retry);

    // R2
    local_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_global) |=> !sts_shared && !sts_retry);

    // R7
    push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !push_ack) |=> push_req && $stable(push_addr));

    // R7
    push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && push_ack) |=> !push_req);

    // R8
    busy_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && snp_valid && snp_global) |=> sts_retry && !sts_shared);

    // R3
    push_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_req) |-> sts_retry && sts_shared);

    // R9
    resv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resv_valid) |->
            $past(snp_valid && snp_global && (snp_type == 3'd4 || snp_type == 3'd5)));

    // R10
    wq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(wq_valid) & ~wq_valid)) |->
            $past(wq_wr || (snp_valid && snp_global && snp_type == 3'd7)));
endmodule

bind snoop_ctl snoop_ctl_chk #(.ADDR_W(ADDR_W), .WQ_DEPTH(WQ_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_valid  (snp_valid),
    .snp_type   (snp_type),
    .snp_global (snp_global),
    .sts_shared (sts_shared),
    .sts_retry  (sts_retry),
    .push_req   (push_req),
    .push_addr  (push_addr),
    .push_ack   (push_ack),
    .resv_valid (resv_valid),
    .wq_wr      (wq_wr),
    .wq_valid   (wq_valid)
);

// File: tb/sim_snoop_ctl.sv
module sim_snoop_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snp_valid = 1'b0;
    logic [31:0] snp_addr = '0;
    logic [2:0]  snp_type = '0;
    logic        snp_global = 1'b0;
    logic        sts_shared, sts_retry, push_req;
    logic [31:0] push_addr;
    logic        push_ack = 1'b0;
    logic        fill_en = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [1:0]  fill_state = '0;
    logic [31:0] probe_addr = '0;
    logic [1:0]  probe_state;
    logic        resv_set = 1'b0;
    logic [31:0] resv_addr = '0;
    logic        resv_valid;
    logic        wq_wr = 1'b0;
    logic [1:0]  wq_slot = '0;
    logic [31:0] wq_addr = '0;
    logic        wq_wr_valid = 1'b0;
    logic [2:0]  wq_valid;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    snoop_ctl u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic fill(input logic [31:0] a, input logic [1:0] s);
        fill_en = 1'b1; fill_addr = a; fill_state = s;
        step();
        fill_en = 1'b0;
    endtask

    task automatic snoop(input logic [31:0] a, input logic [2:0] k, input logic g);
        snp_valid = 1'b1; snp_addr = a; snp_type = k; snp_global = g;
        step();
        snp_valid = 1'b0;
    endtask

    // Returns {shared, retry, push, deferred, final_state}
    function automatic logic [5:0] model(input int k, input int s, input bit g);
        logic sh, rt, pu, df;
        logic [1:0] ns;
        sh = 0; rt = 0; pu = 0; df = 0; ns = 2'(s);
        if (g) begin
            case (k)
                0, 1: begin
                    if (s == 1) sh = 1;
                    if (s == 2) begin sh = 1; ns = 2'd1; end
                    if (s == 3) begin sh = 1; rt = 1; pu = 1; ns = 2'd1; end
                end
                2: if (s == 3) begin sh = 1; rt = 1; pu = 1; ns = 2'd2; end
                3, 4, 5: begin
                    if (s == 1 || s == 2) ns = 2'd0;
                    if (s == 3) begin sh = 1; rt = 1; pu = 1; df = 1; ns = 2'd0; end
                end
                default: if (s != 0) ns = 2'd0;
            endcase
        end
        return {sh, rt, pu, df, ns};
    endfunction

    task automatic run_case(input int k, input int s, input bit g, input logic [31:0] a);
        logic [5:0] e;
        string tag;
        e = model(k, s, g);
        tag = (k <= 1) ? "R3" : (k == 2) ? "R4" : (k <= 5) ? "R5" : "R6";
        if (!g) tag = "R2";
        fill({a[31:5], 5'd0}, 2'(s));
        probe_addr = a;
        snoop(a, 3'(k), g);
        chk(tag, {31'd0, sts_shared}, {31'd0, e[5]});
        chk(tag, {31'd0, sts_retry}, {31'd0, e[4]});
        chk(tag, {31'd0, push_req}, {31'd0, e[3]});
        chk(tag, {30'd0, probe_state}, e[2] ? 32'd3 : {30'd0, e[1:0]});
        if (e[3]) begin
            chk("R7", push_addr, {a[31:5], 5'd0});
            push_ack = 1'b1;
            step();
            push_ack = 1'b0;
            chk("R7", {31'd0, push_req}, 32'd0);
        end else begin
            step();
        end
        chk("R2", {30'd0, sts_shared, sts_retry}, 32'd0);
        chk(tag, {30'd0, probe_state}, {30'd0, e[1:0]});
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", {31'd0, sts_shared}, 32'd0);
        chk("R1", {31'd0, sts_retry}, 32'd0);
        chk("R1", {31'd0, push_req}, 32'd0);
        chk("R1", {31'd0, resv_valid}, 32'd0);
        chk("R1", {29'd0, wq_valid}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            probe_addr = 32'(i) << 5;
            #1;
            chk("R1", {30'd0, probe_state}, 32'd0);
        end

        // Sweep of kind x state x global (R2..R7); offset bits vary (R11)
        for (int k = 0; k < 8; k++)
            for (int s = 0; s < 4; s++)
                for (int g = 0; g < 2; g++)
                    run_case(k, s, g[0],
                        32'h4000_0000 + 32'((k * 8 + s * 2 + g) * 32) + 32'((k + s) % 32));

        // R11 different tag, same index misses
        fill(32'h0000_1020, 2'd3);
        probe_addr = 32'h0000_1020;
        snoop(32'h0000_2020, 3'd0, 1'b1);
        chk("R11", {30'd0, sts_shared, sts_retry}, 32'd0);
        chk("R11", {31'd0, push_req}, 32'd0);
        chk("R11", {30'd0, probe_state}, 32'd3);

        // R8 outstanding write-back: retry only, no change
        fill(32'h0000_3000, 2'd3);
        fill(32'h0000_3020, 2'd1);
        snoop(32'h0000_3000, 3'd3, 1'b1);
        chk("R8", {31'd0, push_req}, 32'd1);
        snoop(32'h0000_3020, 3'd0, 1'b1);
        chk("R8", {31'd0, sts_retry}, 32'd1);
        chk("R8", {31'd0, sts_shared}, 32'd0);
        probe_addr = 32'h0000_3020;
        #1;
        chk("R8", {30'd0, probe_state}, 32'd1);
        probe_addr = 32'h0000_3000;
        #1;
        chk("R5", {30'd0, probe_state}, 32'd3);
        chk("R7", push_addr, 32'h0000_3000);
        step();
        chk("R7", {31'd0, push_req}, 32'd1);
        push_ack = 1'b1;
        step();
        push_ack = 1'b0;
        chk("R5", {30'd0, probe_state}, 32'd0);
        snoop(32'h0000_3020, 3'd0, 1'b1);
        chk("R8", {30'd0, sts_shared, sts_retry}, 32'd2);

        // R9 reservation
        resv_set = 1'b1; resv_addr = 32'h0000_5004;
        step();
        resv_set = 1'b0;
        chk("R9", {31'd0, resv_valid}, 32'd1);
        snoop(32'h0000_5010, 3'd4, 1'b0);
        chk("R9", {31'd0, resv_valid}, 32'd1);
        snoop(32'h0000_5030, 3'd4, 1'b1);
        chk("R9", {31'd0, resv_valid}, 32'd1);
        snoop(32'h0000_5010, 3'd3, 1'b1);
        chk("R9", {31'd0, resv_valid}, 32'd1);
        snoop(32'h0000_5010, 3'd0, 1'b1);
        chk("R9", {31'd0, resv_valid}, 32'd1);
        snoop(32'h0000_501f, 3'd5, 1'b1);
        chk("R9", {31'd0, resv_valid}, 32'd0);
        resv_set = 1'b1;
        step();
        resv_set = 1'b0;
        snoop(32'h0000_5000, 3'd4, 1'b1);
        chk("R9", {31'd0, resv_valid}, 32'd0);

        // R10 write-queue purge
        wq_wr = 1'b1; wq_wr_valid = 1'b1;
        wq_slot = 2'd0; wq_addr = 32'h0000_6000; step();
        wq_slot = 2'd1; wq_addr = 32'h0000_6040; step();
        wq_slot = 2'd2; wq_addr = 32'h0000_6008; step();
        wq_wr = 1'b0;
        chk("R10", {29'd0, wq_valid}, 32'd7);
        snoop(32'h0000_6010, 3'd7, 1'b1);
        chk("R10", {29'd0, wq_valid}, 32'd2);
        snoop(32'h0000_6040, 3'd7, 1'b0);
        chk("R10", {29'd0, wq_valid}, 32'd2);
        snoop(32'h0000_6040, 3'd6, 1'b1);
        chk("R10", {29'd0, wq_valid}, 32'd2);
        snoop(32'h0000_6044, 3'd7, 1'b1);
        chk("R10", {29'd0, wq_valid}, 32'd0);

        // R2 no snoop: quiet
        step();
        chk("R2", {30'd0, sts_shared, sts_retry}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule